// File: doc/BRIEF.md
# Smart Card Answer-To-Reset Parser

This block follows the byte stream that a smart card sends after leaving reset and decodes its structure as the bytes arrive. Bytes come in one at a time over a valid/ready input. The parser walks through the initial character, the format byte, the chained interface-byte groups, the historical bytes and the final check byte. While it does so, it picks out the clock-rate conversion index, the baud-adjustment index and the work waiting integer. These are the values a receiver needs to retune its bit timing once the answer is complete.

The input never applies back-pressure. `in_ready_o` is tied high, so every cycle with `in_valid_i` high transfers one byte, and the source may present a new byte on every cycle. Each counted byte is kept in a raw buffer of `DEPTH` entries that can be read through a combinational index port. When the check byte has been consumed, `done_o` pulses for one cycle. From then on the parser holds its results and ignores further bytes until `restart_i` is pulsed, for example when the card's reset line is released again.

Top module: `atr_parser`

## Requirements
- R1: After `rst_n` or a `restart_i` pulse, `fi_o`=1, `di_o`=1, `wi_o`=10, `byte_cnt_o`=0, `done_o`=0, and every buffer entry reads 0.
- R2: `in_ready_o` is always 1, and a byte is consumed in every cycle where `in_valid_i` is 1.
- R3: A byte of value 0x00 received while the parser waits for the initial character is dropped: it is not counted, it is not stored, and the parser keeps waiting.
- R4: The byte after the initial character is the format byte. Its bits [3:0] give the number of historical bytes, and its bits [7:4] give the interface-byte presence flags.
- R5: In the format byte and in each chaining byte, bit 4 flags byte A, bit 5 flags byte B, bit 6 flags byte C and bit 7 flags a further chaining byte. The present bytes are expected in that order and absent ones are skipped. A chaining byte restarts the scan with its own flags.
- R6: An A byte received while the most recent chaining byte has bits [3:0]=0 loads `fi_o` from its bits [7:4] and `di_o` from its bits [3:0]. The format byte counts as a chaining byte whose bits [3:0] are 0. Any other A byte changes neither output.
- R7: A C byte received while the most recent chaining byte has bits [3:0]=2 loads all 8 bits into `wi_o`. Any other C byte leaves `wi_o` unchanged.
- R8: Once the interface bytes end, exactly the announced number of historical bytes is consumed, and the next byte is the check byte. If the count is 0, the next byte is the check byte.
- R9: `done_o` is high for exactly one cycle, namely the cycle after the check byte is consumed.
- R10: After the check byte, incoming bytes change neither the count, nor the outputs, nor the buffer, and raise no further `done_o` until a restart.
- R11: The k-th counted byte (k from 0) is readable at `rd_idx_i`=k on `rd_data_o`. Bytes past `DEPTH` are counted and parsed but not stored. `byte_cnt_o` saturates at its maximum value.
- R12: A restart in the middle of an answer drops all progress, and the parser waits for the initial character again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Synchronous restart strobe |
| in_valid_i | input | 1 | Byte valid |
| in_ready_o | output | 1 | Byte ready, constant 1 |
| in_data_i | input | 8 | Incoming answer byte |
| fi_o | output | 4 | Clock-rate conversion index |
| di_o | output | 4 | Baud-adjustment index |
| wi_o | output | 8 | Work waiting integer |
| done_o | output | 1 | One-cycle pulse after the check byte |
| byte_cnt_o | output | CNT_W | Number of counted bytes |
| rd_idx_i | input | AW | Buffer read index |
| rd_data_o | output | 8 | Buffer content at `rd_idx_i` |

## Verification
The hardest conditions to reach from the ports are the overflow of the byte buffer and the case where a later group's A byte is still taken as the first group's. Neither occurs in a typical short answer.

To reach the overflow, the stimulus sends a chain of more than seventy chaining bytes, each flagging only a further chaining byte. The bench then reads the last buffer slot and compares the byte count with the true length.

A second answer uses a first chaining byte whose protocol nibble is zero. This shows that the A byte which follows it reloads both indices. A scoreboard queues the expected indices, waiting integer and length for each answer, and compares them on every done pulse.

// File: rtl/atr_pkg.sv
package atr_pkg;

  typedef enum logic [3:0] {
    ST_TS   = 4'd0,
    ST_T0   = 4'd1,
    ST_TA   = 4'd2,
    ST_TB   = 4'd3,
    ST_TC   = 4'd4,
    ST_TD   = 4'd5,
    ST_HIST = 4'd6,
    ST_TCK  = 4'd7,
    ST_DONE = 4'd8
  } atr_state_e;

  // Next field after 'from', given chaining flags in td[7:4] and the
  // remaining historical byte count.
  function automatic atr_state_e after_field(input logic [7:0] td,
                                             input atr_state_e from,
                                             input logic [3:0] hist);
    logic [3:0] flags;
    atr_state_e nxt;
    flags = td[7:4];
    case (from)
      ST_TA:   flags[0]   = 1'b0;
      ST_TB:   flags[1:0] = 2'b00;
      ST_TC:   flags[2:0] = 3'b000;
      default: flags      = td[7:4];
    endcase
    if (flags[0])      nxt = ST_TA;
    else if (flags[1]) nxt = ST_TB;
    else if (flags[2]) nxt = ST_TC;
    else if (flags[3]) nxt = ST_TD;
    else if (hist == 4'd0) nxt = ST_TCK;
    else               nxt = ST_HIST;
    return nxt;
  endfunction

endpackage

// File: rtl/atr_field_fsm.sv
module atr_field_fsm
  import atr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart_i,
  input  logic       take_i,
  input  logic [7:0] data_i,
  output atr_state_e state_o,
  output logic       counted_o,
  output logic       ta1_hit_o,
  output logic       tc2_hit_o,
  output logic       tck_hit_o
);

  atr_state_e state_q, state_d;
  logic [3:0] hist_q, hist_d;
  logic [7:0] td_q, td_d;

  assign state_o   = state_q;
  assign counted_o = take_i && (state_q != ST_DONE) &&
                     !((state_q == ST_TS) && (data_i == 8'h00));
  assign ta1_hit_o = take_i && (state_q == ST_TA) && (td_q[3:0] == 4'h0);
  assign tc2_hit_o = take_i && (state_q == ST_TC) && (td_q[3:0] == 4'h2);
  assign tck_hit_o = take_i && (state_q == ST_TCK);

  always_comb begin
    state_d = state_q;
    hist_d  = hist_q;
    td_d    = td_q;
    if (take_i) begin
      case (state_q)
        ST_TS: begin
          if (data_i != 8'h00) state_d = ST_T0;
        end
        ST_T0: begin
          hist_d  = data_i[3:0];
          td_d    = {data_i[7:4], 4'h0};
          state_d = after_field({data_i[7:4], 4'h0}, ST_TD, data_i[3:0]);
        end
        ST_TA, ST_TB, ST_TC: begin
          state_d = after_field(td_q, state_q, hist_q);
        end
        ST_TD: begin
          td_d    = data_i;
          state_d = after_field(data_i, ST_TD, hist_q);
        end
        ST_HIST: begin
          hist_d = hist_q - 4'd1;
          if (hist_q <= 4'd1) state_d = ST_TCK;
        end
        ST_TCK:  state_d = ST_DONE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TS;
      hist_q  <= 4'd0;
      td_q    <= 8'h00;
    end else if (restart_i) begin
      state_q <= ST_TS;
      hist_q  <= 4'd0;
      td_q    <= 8'h00;
    end else begin
      state_q <= state_d;
      hist_q  <= hist_d;
      td_q    <= td_d;
    end
  end

  AST_TS_ZERO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !restart_i && state_q == ST_TS && data_i == 8'h00) |=> (state_q == ST_TS)); // R3
  AST_TCK_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tck_hit_o && !restart_i) |=> (state_q == ST_DONE)); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && !restart_i) |=> (state_q == ST_DONE)); // R10
  AST_RESTART_TS: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (state_q == ST_TS)); // R12
  AST_HIST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HIST) |-> (hist_q != 4'd0)); // R8

endmodule

// File: rtl/atr_param_regs.sv
module atr_param_regs #(
  parameter logic [3:0] FI_RST = 4'd1,
  parameter logic [3:0] DI_RST = 4'd1,
  parameter logic [7:0] WI_RST = 8'd10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart_i,
  input  logic       ta1_hit_i,
  input  logic       tc2_hit_i,
  input  logic [7:0] data_i,
  output logic [3:0] fi_o,
  output logic [3:0] di_o,
  output logic [7:0] wi_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fi_o <= FI_RST;
      di_o <= DI_RST;
      wi_o <= WI_RST;
    end else if (restart_i) begin
      fi_o <= FI_RST;
      di_o <= DI_RST;
      wi_o <= WI_RST;
    end else begin
      if (ta1_hit_i) begin
        fi_o <= data_i[7:4];
        di_o <= data_i[3:0];
      end
      if (tc2_hit_i) wi_o <= data_i;
    end
  end

  AST_RESTART_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (fi_o == FI_RST && di_o == DI_RST && wi_o == WI_RST)); // R1
  AST_WI_ONLY_TC2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !tc2_hit_i) |=> $stable(wi_o)); // R7
  AST_FIDI_ONLY_TA1: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !ta1_hit_i) |=> ($stable(fi_o) && $stable(di_o))); // R6

endmodule

// File: rtl/atr_byte_store.sv
module atr_byte_store #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             counted_i,
  input  logic [7:0]       data_i,
  input  logic [AW-1:0]    rd_idx_i,
  output logic [7:0]       rd_data_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(DEPTH);

  logic [7:0] mem_q [DEPTH];
  logic       room;

  assign room      = (cnt_o < CNT_CAP);
  assign rd_data_o = mem_q[rd_idx_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (restart_i) begin
      cnt_o <= '0;
    end else if (counted_i && cnt_o != CNT_MAX) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= 8'h00;
      end else if (restart_i) begin
        mem_q[g] <= 8'h00;
      end else if (counted_i && room && cnt_o[AW-1:0] == AW'(g)) begin
        mem_q[g] <= data_i;
      end
    end
  end

  AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_i |=> (cnt_o >= $past(cnt_o))); // R11
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !counted_i) |=> $stable(cnt_o)); // R10

endmodule

// File: rtl/atr_parser.sv
module atr_parser
  import atr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter logic [3:0] FI_RST = 4'd1,
  parameter logic [3:0] DI_RST = 4'd1,
  parameter logic [7:0] WI_RST = 8'd10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [7:0]       in_data_i,
  output logic [3:0]       fi_o,
  output logic [3:0]       di_o,
  output logic [7:0]       wi_o,
  output logic             done_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  input  logic [AW-1:0]    rd_idx_i,
  output logic [7:0]       rd_data_o
);

  atr_state_e state;
  logic take, counted, ta1_hit, tc2_hit, tck_hit;

  assign in_ready_o = 1'b1;
  assign take       = in_valid_i && in_ready_o;

  atr_field_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart_i),
    .take_i    (take),
    .data_i    (in_data_i),
    .state_o   (state),
    .counted_o (counted),
    .ta1_hit_o (ta1_hit),
    .tc2_hit_o (tc2_hit),
    .tck_hit_o (tck_hit)
  );

  atr_param_regs #(
    .FI_RST (FI_RST),
    .DI_RST (DI_RST),
    .WI_RST (WI_RST)
  ) u_params (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart_i),
    .ta1_hit_i (ta1_hit),
    .tc2_hit_i (tc2_hit),
    .data_i    (in_data_i),
    .fi_o      (fi_o),
    .di_o      (di_o),
    .wi_o      (wi_o)
  );

  atr_byte_store #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .AW    (AW)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart_i),
    .counted_i (counted),
    .data_i    (in_data_i),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o),
    .cnt_o     (byte_cnt_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         done_o <= 1'b0;
    else if (restart_i) done_o <= 1'b0;
    else                done_o <= tck_hit;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (state == ST_DONE)); // R9
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o); // R2

endmodule

// File: tb/atr_parser_tb.sv
module atr_parser_tb;

  localparam int DEPTH = 64;
  localparam int CNT_W = 8;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = 8'h00;
  logic [3:0] fi, di;
  logic [7:0] wi;
  logic done;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0] rd_idx = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    int fi; int di; int wi; int cnt;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  atr_parser #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .restart_i(restart),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .fi_o(fi), .di_o(di), .wi_o(wi), .done_o(done),
    .byte_cnt_o(cnt), .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic expect_done(input int f, input int d, input int w, input int c);
    exp_t e;
    e.fi = f; e.di = d; e.wi = w; e.cnt = c;
    exp_q.push_back(e);
  endtask

  task automatic read_chk(input int idx, input int exp, input string req);
    @(negedge clk);
    rd_idx = AW'(idx);
    #1;
    chk(rd_data == 8'(exp), req, rd_data, exp);
  endtask

  // Monitor: compare every done pulse against the scoreboard (R9, R6, R7, R8)
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9/R10 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(fi == 4'(e.fi), "R6 fi at done", fi, e.fi);
        chk(di == 4'(e.di), "R6 di at done", di, e.di);
        chk(wi == 8'(e.wi), "R7 wi at done", wi, e.wi);
        chk(cnt == CNT_W'(e.cnt), "R8 count at done", cnt, e.cnt);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(fi == 4'd1, "R1 fi reset", fi, 1);
    chk(di == 4'd1, "R1 di reset", di, 1);
    chk(wi == 8'd10, "R1 wi reset", wi, 10);
    chk(cnt == 0, "R1 count reset", cnt, 0);
    chk(done == 1'b0, "R1 done reset", done, 0);
    read_chk(5, 0, "R1 buffer reset");
    // R2
    chk(in_ready == 1'b1, "R2 ready", in_ready, 1);

    // Minimal answer with a leading zero (R3) and no historical bytes (R8)
    send(8'h00);
    chk(cnt == 0, "R3 zero not counted", cnt, 0);
    send(8'h3B);
    send(8'h00);
    expect_done(1, 1, 10, 3);
    send(8'h55);
    read_chk(0, 8'h3B, "R3 zero not stored");
    read_chk(2, 8'h55, "R11 slot 2");
    // R10: bytes after completion ignored
    send(8'h11);
    send(8'hA5);
    chk(cnt == 3, "R10 count frozen", cnt, 3);
    chk(fi == 4'd1 && di == 4'd1, "R10 params frozen", {fi, di}, 8'h11);
    read_chk(3, 0, "R10 not stored");

    // Full chain: TA1/TB1/TC1/TD1(T=2) then TA2/TC2, two historical (R4 R5 R6 R7 R8)
    do_restart();
    send(8'h3B); send(8'hF2); send(8'h96); send(8'h00); send(8'h05);
    send(8'h52); send(8'h33); send(8'h20);
    chk(wi == 8'h20, "R7 TC2 loads wi", wi, 8'h20);
    chk(fi == 4'h9 && di == 4'h6, "R6 TA2 with nonzero group ignored", {fi, di}, 8'h96);
    send(8'h41); send(8'h42);
    chk(cnt == 10, "R4 historical consumed", cnt, 10);
    expect_done(9, 6, 8'h20, 11);
    send(8'h99);
    read_chk(1, 8'hF2, "R4 format byte stored");

    // Chaining byte with protocol nibble 0 makes the next A byte reload (R6)
    do_restart();
    send(8'h3B); send(8'h80); send(8'h10); send(8'h18);
    expect_done(1, 8, 10, 5);
    send(8'h00);

    // Long answer beyond the buffer (R11)
    do_restart();
    send(8'h3B); send(8'h81);
    for (int i = 0; i < 70; i++) send(8'h80);
    send(8'h00); send(8'h77);
    expect_done(1, 1, 10, 75);
    send(8'h66);
    read_chk(63, 8'h80, "R11 last slot");
    read_chk(1, 8'h81, "R11 early slot");

    // Restart mid-answer (R12, R1)
    do_restart();
    send(8'h3B); send(8'hF0); send(8'h95);
    chk(fi == 4'h9, "R6 TA1 loaded", fi, 9);
    do_restart();
    chk(fi == 4'd1 && di == 4'd1, "R12 params cleared", {fi, di}, 8'h11);
    chk(cnt == 0, "R12 count cleared", cnt, 0);
    read_chk(0, 0, "R12 buffer cleared");
    send(8'h00); send(8'h3B); send(8'h00);
    expect_done(1, 1, 10, 3);
    send(8'hAA);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all done pulses seen", exp_q.size(), 0);
    finish_run();
  end

endmodule